// File: doc/BRIEF.md
# Memory Region Attribute Selector

This block decides, for every memory access, whether the access may be cached and which byte order applies to it. Software programs a small bank of region templates through a register write port. Each template has an enable bit, a base, a mask, a cache-enable bit and a big-endian bit. A single default control word supplies the cache-enable and byte-order attributes for external accesses that no template claims. Two fixed address spaces are decoded ahead of the templates. The top 16 MB are the memory-mapped register space and never use the templates. A low window is internal data RAM, which is never cacheable and always takes its byte order from the default word.

A lookup is issued by raising `req_valid` with the address given in 8-byte units on `req_blk`, so `req_blk` holds byte-address bits [31:3]. The attributes appear one cycle later, qualified by `rsp_valid`. The default control word responds differently to the two reset sources. A hardware reset clears the default cache-enable bit and loads the default byte order from the boot configuration bit. A software re-initialization clears only the cache-enable bit. A two-state lookup FSM drives `rsp_valid`. In LK_IDLE there is no response pending. In LK_HOLD a registered result is presented. The FSM moves LK_IDLE→LK_HOLD and LK_HOLD→LK_HOLD when a request is present, and LK_HOLD→LK_IDLE and LK_IDLE→LK_IDLE when none is. Hardware reset forces LK_IDLE.

Top module: `mem_attr_sel`

## Requirements
- R1: While `hw_rst` is high, every template's enable bit is cleared. After reset, a template that has not been enabled by a write never matches, whatever its other fields hold.
- R2: A cycle with `hw_rst` high clears the default cache-enable bit. The same cycle loads the default big-endian bit from `boot_cfg_be`. Later changes of `boot_cfg_be` have no effect until the next hardware reset.
- R3: A cycle with `sw_reinit` high (and `hw_rst` low) clears the default cache-enable bit and leaves the default big-endian bit unchanged. A default-word write in the same cycle is dropped. Template contents are not affected.
- R4: Requests with address bits [31:24] equal to 8'hFF are register-space accesses. They report space code 3, are non-cacheable and use the default big-endian bit. No template is consulted, so the overlap flag is 0 and the template index is 0.
- R5: Requests with address bits [31:10] all zero are internal-RAM accesses. They report space code 2, are always non-cacheable and use the default big-endian bit, even when an enabled template covers the address.
- R6: Template n holds two words. The control word at `cfg_addr` 2n holds the base in bits [31:3], big-endian in bit 2, cache-enable in bit 1 and enable in bit 0. The mask word at `cfg_addr` 2n+1 holds the mask in bits [31:3]. An external access matches the template when it is enabled and ((address XOR base) AND mask) is zero over bits [31:3]. A matching access reports space code 1, the template's index and its two attribute bits.
- R7: When more than one enabled template matches, the lowest-numbered one supplies the index and attributes, and `rsp_overlap` is 1. Otherwise `rsp_overlap` is 0.
- R8: The default word is written at `cfg_addr` 2×NUM_TPL, with cache-enable in bit 0 and big-endian in bit 1. An external access that matches no enabled template reports space code 0 with these two default bits.
- R9: `rsp_valid` is 1 in exactly the cycles that follow a cycle with `req_valid` high and `hw_rst` low. The result reflects configuration written before the request's clock edge, so a write made in the same cycle as a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| sw_reinit | input | 1 | Software re-initialization pulse |
| boot_cfg_be | input | 1 | Bit 31 of the boot memory-configuration word (big-endian seed) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request |
| req_blk | input | 29 | Access address bits [31:3] |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_space | output | 2 | 0 default, 1 template, 2 internal RAM, 3 register space |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_big_endian | output | 1 | Access uses big-endian byte order |
| rsp_tpl_idx | output | 1 | Index of the winning template |
| rsp_overlap | output | 1 | More than one enabled template matched |

## Verification
The assertions check on every cycle that results for RAM and register space are never cacheable, that RAM results carry the default byte order, and that `rsp_valid` follows `req_valid` by exactly one cycle. They also check how the default word behaves on the cycle after each kind of reset, that no template is enabled right after a hardware reset, and that an overlap is flagged only on a template hit with index 0. Only the bench's scenarios can show that the correct template and attributes are chosen for given base and mask patterns. They also show that a write becomes visible exactly one lookup later, that a dropped default write during re-initialization leaves nothing behind, and that templates survive re-initialization but not a hardware reset.

// File: rtl/mas_pkg.sv
package mas_pkg;

    localparam int ADDR_W  = 32;
    localparam int BLK_LSB = 3;
    localparam int BLK_W   = ADDR_W - BLK_LSB;

    typedef enum logic [1:0] {
        SPC_DFLT = 2'd0,
        SPC_TPL  = 2'd1,
        SPC_RAM  = 2'd2,
        SPC_MMR  = 2'd3
    } space_e;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_HOLD = 1'b1
    } lk_state_e;

    typedef struct packed {
        logic cacheable;
        logic big_endian;
    } attr_t;

endpackage

// File: rtl/mas_dflt_ctl.sv
module mas_dflt_ctl (
    input  logic clk,
    input  logic hw_rst,
    input  logic sw_reinit,
    input  logic boot_be,
    input  logic wr_en,
    input  logic wr_cache,
    input  logic wr_be,
    output logic dcen,
    output logic dbe
);

    // Hardware reset seeds byte order; re-init only drops caching.
    always_ff @(posedge clk) begin
        if (hw_rst) begin
            dcen <= 1'b0;
            dbe  <= boot_be;
        end else if (sw_reinit) begin
            dcen <= 1'b0;
        end else if (wr_en) begin
            dcen <= wr_cache;
            dbe  <= wr_be;
        end
    end

    // R2: the cycle after a hardware reset shows caching off and the seeded order
    p_reset_dcen_r2: assert property (@(posedge clk) disable iff (hw_rst)
        $past(hw_rst) |-> !dcen);
    p_reset_be_r2: assert property (@(posedge clk) disable iff (hw_rst)
        $past(hw_rst) |-> (dbe == $past(boot_be)));
    // R3: re-initialization clears caching and keeps byte order
    p_reinit_dcen_r3: assert property (@(posedge clk) disable iff (hw_rst)
        sw_reinit |=> !dcen);
    p_reinit_be_r3: assert property (@(posedge clk) disable iff (hw_rst)
        sw_reinit |=> $stable(dbe));

endmodule

// File: rtl/mas_tpl_bank.sv
module mas_tpl_bank
    import mas_pkg::*;
#(
    parameter int NUM_TPL = 2,
    parameter int IDX_W   = 1,
    parameter int WSEL_W  = 2
) (
    input  logic                 clk,
    input  logic                 hw_rst,
    input  logic                 wr_en,
    input  logic [WSEL_W-1:0]    wr_idx,
    input  logic                 wr_mask,
    input  logic [ADDR_W-1:0]    wr_data,
    input  logic [BLK_W-1:0]     blk,
    output logic                 any_hit,
    output logic [IDX_W-1:0]     win_idx,
    output attr_t                win_attr,
    output logic                 overlap
);

    logic [NUM_TPL-1:0] hit;
    attr_t              attr_v [NUM_TPL];

    generate
        for (genvar g = 0; g < NUM_TPL; g++) begin : g_tpl
            logic             en_q;
            logic [BLK_W-1:0] base_q;
            logic [BLK_W-1:0] mask_q;
            attr_t            a_q;
            logic             sel;

            assign sel = wr_en && !hw_rst && (wr_idx == WSEL_W'(g));

            // Only the enable bit has a reset value.
            always_ff @(posedge clk) begin
                if (hw_rst)
                    en_q <= 1'b0;
                else if (sel && !wr_mask)
                    en_q <= wr_data[0];
            end

            always_ff @(posedge clk) begin
                if (sel) begin
                    if (wr_mask) begin
                        mask_q <= wr_data[ADDR_W-1:BLK_LSB];
                    end else begin
                        base_q       <= wr_data[ADDR_W-1:BLK_LSB];
                        a_q.cacheable  <= wr_data[1];
                        a_q.big_endian <= wr_data[2];
                    end
                end
            end

            assign hit[g]    = en_q && (((blk ^ base_q) & mask_q) == '0);
            assign attr_v[g] = a_q;

            // R1: no template is live straight after a hardware reset
            p_tpl_off_after_reset_r1: assert property (@(posedge clk) disable iff (hw_rst)
                $past(hw_rst) |-> !en_q);
        end
    endgenerate

    // Lowest-numbered hit wins.
    always_comb begin
        any_hit  = |hit;
        win_idx  = '0;
        win_attr = '0;
        for (int i = NUM_TPL - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win_idx  = IDX_W'(i);
                win_attr = attr_v[i];
            end
        end
        overlap = ($countones(hit) > 1);
    end

    // R7: the chosen index is really one of the matching templates
    p_win_is_hit_r7: assert property (@(posedge clk) disable iff (hw_rst)
        any_hit |-> hit[win_idx]);
    p_overlap_needs_hit_r7: assert property (@(posedge clk) disable iff (hw_rst)
        overlap |-> (any_hit && win_idx == '0));

endmodule

// File: rtl/mas_lookup.sv
module mas_lookup
    import mas_pkg::*;
#(
    parameter int          IDX_W     = 1,
    parameter int          RAM_BYTES = 1024,
    parameter int          MMR_TAG_W = 8,
    parameter logic [7:0]  MMR_TAG   = 8'hFF
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  logic              req_valid,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic              dcen,
    input  logic              dbe,
    input  logic              any_hit,
    input  logic [IDX_W-1:0]  win_idx,
    input  attr_t             win_attr,
    input  logic              overlap,
    output logic              rsp_valid,
    output logic [1:0]        rsp_space,
    output logic              rsp_cacheable,
    output logic              rsp_big_endian,
    output logic [IDX_W-1:0]  rsp_tpl_idx,
    output logic              rsp_overlap
);

    localparam int RAM_BLK_BITS = $clog2(RAM_BYTES) - BLK_LSB;

    lk_state_e state_q, state_d;

    logic             is_mmr, is_ram;
    space_e           spc_d;
    attr_t            attr_d;
    logic [IDX_W-1:0] idx_d;
    logic             ovl_d;

    // Fixed spaces take precedence over the templates.
    always_comb begin
        is_mmr = (req_blk[BLK_W-1 -: MMR_TAG_W] == MMR_TAG[MMR_TAG_W-1:0]);
        is_ram = (req_blk[BLK_W-1:RAM_BLK_BITS] == '0);
        idx_d  = '0;
        ovl_d  = 1'b0;
        if (is_mmr) begin
            spc_d  = SPC_MMR;
            attr_d = '{cacheable: 1'b0, big_endian: dbe};
        end else if (is_ram) begin
            spc_d  = SPC_RAM;
            attr_d = '{cacheable: 1'b0, big_endian: dbe};
        end else if (any_hit) begin
            spc_d  = SPC_TPL;
            attr_d = win_attr;
            idx_d  = win_idx;
            ovl_d  = overlap;
        end else begin
            spc_d  = SPC_DFLT;
            attr_d = '{cacheable: dcen, big_endian: dbe};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (hw_rst) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: state_d = req_valid ? LK_HOLD : LK_IDLE;
            LK_HOLD: state_d = req_valid ? LK_HOLD : LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            LK_IDLE: rsp_valid = 1'b0;
            LK_HOLD: rsp_valid = 1'b1;
            default: rsp_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            rsp_space      <= SPC_DFLT;
            rsp_cacheable  <= 1'b0;
            rsp_big_endian <= 1'b0;
            rsp_tpl_idx    <= '0;
            rsp_overlap    <= 1'b0;
        end else if (req_valid) begin
            rsp_space      <= spc_d;
            rsp_cacheable  <= attr_d.cacheable;
            rsp_big_endian <= attr_d.big_endian;
            rsp_tpl_idx    <= idx_d;
            rsp_overlap    <= ovl_d;
        end
    end

    // R9: response timing
    p_valid_follows_req_r9: assert property (@(posedge clk) disable iff (hw_rst)
        req_valid |=> rsp_valid);
    p_no_req_no_valid_r9: assert property (@(posedge clk) disable iff (hw_rst)
        !req_valid |=> !rsp_valid);
    // R5: internal RAM never cacheable, order from the default word
    p_ram_uncached_r5: assert property (@(posedge clk) disable iff (hw_rst)
        (rsp_valid && rsp_space == SPC_RAM) |-> !rsp_cacheable);
    p_ram_order_r5: assert property (@(posedge clk) disable iff (hw_rst)
        (rsp_valid && rsp_space == SPC_RAM) |-> (rsp_big_endian == $past(dbe)));
    // R4: register space bypasses templates
    p_mmr_bypass_r4: assert property (@(posedge clk) disable iff (hw_rst)
        (rsp_valid && rsp_space == SPC_MMR) |-> (!rsp_cacheable && !rsp_overlap));
    // R7: overlap only reported on a template hit
    p_overlap_tpl_only_r7: assert property (@(posedge clk) disable iff (hw_rst)
        (rsp_valid && rsp_overlap) |-> (rsp_space == SPC_TPL && rsp_tpl_idx == '0));

endmodule

// File: rtl/mem_attr_sel.sv
module mem_attr_sel
    import mas_pkg::*;
#(
    parameter int          NUM_TPL   = 2,
    parameter int          RAM_BYTES = 1024,
    parameter int          MMR_TAG_W = 8,
    parameter logic [7:0]  MMR_TAG   = 8'hFF,
    localparam int         CFG_AW    = $clog2(2 * NUM_TPL + 1),
    localparam int         IDX_W     = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1
) (
    input  logic              clk,
    input  logic              hw_rst,
    input  logic              sw_reinit,
    input  logic              boot_cfg_be,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [28:0]       req_blk,
    output logic              rsp_valid,
    output logic [1:0]        rsp_space,
    output logic              rsp_cacheable,
    output logic              rsp_big_endian,
    output logic [IDX_W-1:0]  rsp_tpl_idx,
    output logic              rsp_overlap
);

    localparam int WSEL_W   = CFG_AW - 1;
    localparam int DFLT_SEL = 2 * NUM_TPL;

    logic             tpl_we, dflt_we;
    logic             dcen, dbe;
    logic             any_hit, overlap;
    logic [IDX_W-1:0] win_idx;
    attr_t            win_attr;

    assign tpl_we  = cfg_we && (int'(cfg_addr) < DFLT_SEL);
    assign dflt_we = cfg_we && (int'(cfg_addr) == DFLT_SEL);

    mas_dflt_ctl u_dflt (
        .clk       (clk),
        .hw_rst    (hw_rst),
        .sw_reinit (sw_reinit),
        .boot_be   (boot_cfg_be),
        .wr_en     (dflt_we),
        .wr_cache  (cfg_wdata[0]),
        .wr_be     (cfg_wdata[1]),
        .dcen      (dcen),
        .dbe       (dbe)
    );

    mas_tpl_bank #(
        .NUM_TPL (NUM_TPL),
        .IDX_W   (IDX_W),
        .WSEL_W  (WSEL_W)
    ) u_bank (
        .clk      (clk),
        .hw_rst   (hw_rst),
        .wr_en    (tpl_we),
        .wr_idx   (cfg_addr[CFG_AW-1:1]),
        .wr_mask  (cfg_addr[0]),
        .wr_data  (cfg_wdata),
        .blk      (req_blk),
        .any_hit  (any_hit),
        .win_idx  (win_idx),
        .win_attr (win_attr),
        .overlap  (overlap)
    );

    mas_lookup #(
        .IDX_W     (IDX_W),
        .RAM_BYTES (RAM_BYTES),
        .MMR_TAG_W (MMR_TAG_W),
        .MMR_TAG   (MMR_TAG)
    ) u_lookup (
        .clk            (clk),
        .hw_rst         (hw_rst),
        .req_valid      (req_valid),
        .req_blk        (req_blk),
        .dcen           (dcen),
        .dbe            (dbe),
        .any_hit        (any_hit),
        .win_idx        (win_idx),
        .win_attr       (win_attr),
        .overlap        (overlap),
        .rsp_valid      (rsp_valid),
        .rsp_space      (rsp_space),
        .rsp_cacheable  (rsp_cacheable),
        .rsp_big_endian (rsp_big_endian),
        .rsp_tpl_idx    (rsp_tpl_idx),
        .rsp_overlap    (rsp_overlap)
    );

endmodule

// File: tb/tb_mem_attr_sel.sv
`timescale 1ns/1ps
module tb_mem_attr_sel;

    logic        clk = 1'b0;
    logic        hw_rst, sw_reinit, boot_cfg_be, cfg_we, req_valid;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [28:0] req_blk;
    logic        rsp_valid, rsp_cacheable, rsp_big_endian, rsp_overlap;
    logic [1:0]  rsp_space;
    logic [0:0]  rsp_tpl_idx;

    always #2.5 clk = ~clk;

    mem_attr_sel dut (
        .clk(clk), .hw_rst(hw_rst), .sw_reinit(sw_reinit), .boot_cfg_be(boot_cfg_be),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_blk(req_blk),
        .rsp_valid(rsp_valid), .rsp_space(rsp_space), .rsp_cacheable(rsp_cacheable),
        .rsp_big_endian(rsp_big_endian), .rsp_tpl_idx(rsp_tpl_idx), .rsp_overlap(rsp_overlap)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R2";

    // Behavioural reference state
    bit [31:0] m_base [2];
    bit [31:0] m_mask [2];
    bit        m_en [2];
    bit        m_c [2];
    bit        m_be [2];
    bit        m_dcen, m_dbe;
    bit        e_v;
    bit [1:0]  e_sp;
    bit        e_c, e_be, e_ovl;
    bit [0:0]  e_idx;

    task automatic fail(string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic predict(input bit [31:0] a);
        int nh = 0;
        e_ovl = 0; e_idx = 0;
        if (a[31:24] == 8'hFF) begin
            e_sp = 3; e_c = 0; e_be = m_dbe;
        end else if (a < 32'd1024) begin
            e_sp = 2; e_c = 0; e_be = m_dbe;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (m_en[i] && (((a ^ m_base[i]) & m_mask[i] & 32'hFFFF_FFF8) == 0)) begin
                    if (nh == 0) begin e_idx = 1'(i); e_c = m_c[i]; e_be = m_be[i]; end
                    nh++;
                end
            end
            if (nh == 0) begin e_sp = 0; e_c = m_dcen; e_be = m_dbe; end
            else e_sp = 1;
            e_ovl = (nh > 1);
        end
    endtask

    task automatic tick();
        e_v = req_valid && !hw_rst;
        if (e_v) predict({req_blk, 3'b000});
        if (hw_rst) begin
            m_en[0] = 0; m_en[1] = 0; m_dcen = 0; m_dbe = boot_cfg_be;
        end else begin
            if (cfg_we && cfg_addr < 4) begin
                if (cfg_addr[0]) m_mask[cfg_addr[1]] = cfg_wdata;
                else begin
                    m_base[cfg_addr[1]] = cfg_wdata;
                    m_en[cfg_addr[1]]   = cfg_wdata[0];
                    m_c[cfg_addr[1]]    = cfg_wdata[1];
                    m_be[cfg_addr[1]]   = cfg_wdata[2];
                end
            end
            if (sw_reinit) m_dcen = 0;
            else if (cfg_we && cfg_addr == 4) begin
                m_dcen = cfg_wdata[0]; m_dbe = cfg_wdata[1];
            end
        end
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== e_v) fail("rsp_valid", int'(rsp_valid), int'(e_v));
        else if (e_v) begin
            if (rsp_space !== e_sp)         fail("rsp_space", int'(rsp_space), int'(e_sp));
            if (rsp_cacheable !== e_c)      fail("rsp_cacheable", int'(rsp_cacheable), int'(e_c));
            if (rsp_big_endian !== e_be)    fail("rsp_big_endian", int'(rsp_big_endian), int'(e_be));
            if (rsp_tpl_idx !== e_idx)      fail("rsp_tpl_idx", int'(rsp_tpl_idx), int'(e_idx));
            if (rsp_overlap !== e_ovl)      fail("rsp_overlap", int'(rsp_overlap), int'(e_ovl));
        end
        hw_rst = 0; sw_reinit = 0; cfg_we = 0; req_valid = 0;
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick();
    endtask

    task automatic look(input bit [31:0] a);
        req_valid = 1; req_blk = a[31:3]; tick();
    endtask

    task automatic tpl(input int n, input bit [31:0] base, input bit [31:0] mask,
                       input bit c, input bit be, input bit en);
        wr(3'(2 * n + 1), mask & 32'hFFFF_FFF8);
        wr(3'(2 * n), (base & 32'hFFFF_FFF8) | {29'd0, be, c, en});
    endtask

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        hw_rst = 1; sw_reinit = 0; boot_cfg_be = 1; cfg_we = 0; cfg_addr = 0;
        cfg_wdata = 0; req_valid = 0; req_blk = 0;
        // R2 / R9: reset state, no response during reset
        tag = "R2"; hw_rst = 1; tick(); hw_rst = 1; tick();
        boot_cfg_be = 0;                      // R2: not re-sampled after reset
        tag = "R1"; look(32'h4000_0000); look(32'h8000_1000);   // R1/R8 defaults, be=1
        // R9: write and lookup in same cycle sees old default, next sees new
        tag = "R9"; cfg_we = 1; cfg_addr = 4; cfg_wdata = 32'h1; req_valid = 1;
        req_blk = 29'h1000_0000; tick();
        look(32'h8000_0000);
        tag = "R9"; tick(); tick();           // idle: no valid
        // R6: single template hit
        tag = "R6"; tpl(0, 32'h4000_0000, 32'hF000_0000, 1, 1, 1);
        look(32'h4123_4560); look(32'h5000_0000);
        // R7: overlapping templates
        tag = "R7"; tpl(1, 32'h4000_0000, 32'hC000_0000, 0, 0, 1);
        look(32'h4000_0008); look(32'h7000_0000);
        // R5: RAM covered by template
        tag = "R5"; tpl(1, 32'h0000_0000, 32'hF000_0000, 1, 0, 1);
        look(32'h0000_0100); look(32'h0000_03F8); look(32'h0000_1000);
        // R4: register space with a catch-all template
        tag = "R4"; tpl(1, 32'h0000_0000, 32'h0000_0000, 1, 0, 1);
        look(32'hFF00_0010); look(32'hFE00_0000);
        // R3: re-init with concurrent default write
        tag = "R3"; wr(3'd1, 32'hF000_0000);
        wr(4, 32'h1);
        sw_reinit = 1; cfg_we = 1; cfg_addr = 4; cfg_wdata = 32'h3; tick();
        look(32'h9000_0000); look(32'h4000_0000); look(32'h0000_0040);
        // R6: disabling a template
        tag = "R6"; wr(3'd0, 32'h4000_0006); look(32'h4000_0000);
        // R1 / R2: second hardware reset with other boot seed
        tag = "R1"; boot_cfg_be = 0; hw_rst = 1; req_valid = 1; tick();
        boot_cfg_be = 1;
        look(32'h4000_0000); look(32'h0000_1000);
        tag = "R8"; wr(4, 32'h3); look(32'hA000_0000);
        tag = "R9"; req_valid = 1; req_blk = 29'h0; tick(); look(32'hFF12_3450); tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule